// File: doc/BRIEF.md
# Read Burst Stop Sequencer

This block sequences the read data window of a double-data-rate DRAM. It samples the command pins on the rising clock edge. On a read, optionally with auto-precharge, it latches the burst length and CAS latency. For each clock period it then reports which half of the period carries a valid data beat. It also reports in which halves the data strobe is driven. Timing is kept in half-cycle slots, so a CAS latency of 2.5 shifts the window by one clock phase. All outputs are registered on the rising edge.

A read may be cut short by the burst stop command. Where the stop is legal, no beat is produced at or after the half-cycle slot that lies one CAS latency after the stop edge. The strobe window closes at the same slot. A stop that comes too late to remove any beat leaves the burst alone. A stop during a write burst, a stop during a read with auto-precharge, or a stop with no burst at all is reported on a fault code for one period. In none of these cases does the fault change the data window or the write timing.

Top module: `rd_burst_stop_seq`

## Requirements
- R1: The command pins are sampled on the rising edge with the encoding (cs_n,ras_n,cas_n,we_n). Read is 0101, write is 0100 and burst stop is 0110. Any pattern with cs_n high, and every other pattern, is ignored and has no effect on a running read.
- R2: Half-cycle slot 2k is the first half of the k-th period after the read command edge (period 0 begins at that edge), and slot 2k+1 is the second half. The CAS latency in half cycles is 4 + cl_sel, which gives 2, 2.5, 3 and 3.5 cycles. dq_valid[0] flags the first half and dq_valid[1] the second half. Beats occupy slots CAS latency through CAS latency + burst length − 1.
- R3: The burst length is 2 for bl_sel=0, 4 for bl_sel=1 and 8 for bl_sel=2 or 3. Burst length and CAS latency are captured at the read command.
- R4: dqs_oe uses the same half mapping as dq_valid. It is high from one half-cycle before the first beat up to and including the last beat produced, so it is never low where dq_valid is high.
- R5: A burst stop at an edge s periods after a plain read suppresses every beat at slot 2s + CAS latency or later, and the strobe closes at that slot too. This holds for every burst length.
- R6: A legal stop whose cut-off slot is at or beyond the natural end of the burst changes nothing and gives fault code 0.
- R7: A burst stop in periods 1 through burst length/2 after a write command gives stop_fault=1 in the following period. It does not shorten the write window, so a later stop inside that window is still flagged as 1.
- R8: A burst stop during a live read with auto-precharge gives stop_fault=2, and the burst runs to its full length.
- R9: A burst stop with neither a live read nor a write window gives stop_fault=3. stop_fault is 0 in every period that does not follow a stop edge.
- R10: A write command ends a running read window, with both outputs low from the period that begins at the write edge. A new read command restarts the sequence with its own settings.
- R11: While rst_n is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands sampled on rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| auto_pre | input | 1 | Read carries auto-precharge when high |
| bl_sel | input | 2 | Burst length select |
| cl_sel | input | 2 | CAS latency select in half cycles above 2 |
| dq_valid | output | 2 | Beat valid per half of the current period |
| dqs_oe | output | 2 | Strobe drive enable per half of the current period |
| stop_fault | output | 2 | Illegal stop cause, valid one period after the stop |

## Verification
A wrong period counter or latency register shows up as dq_valid shifted by whole or half periods. The shift appears from the first beat on, within at most eight periods of the read command. A corrupted end slot shows up as a burst one or more beats too long or too short, or as a strobe that outlives its data. It becomes visible in the period where the burst should have ended. A stale write window or auto-precharge flag shows up as a wrong stop_fault code one period after the next stop command. The bench therefore places stops at every distance from the read and write edges, including those next to the window limits.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

   typedef enum logic [1:0] {
      FLT_NONE     = 2'd0,
      FLT_IN_WRITE = 2'd1,
      FLT_AP_READ  = 2'd2,
      FLT_NO_BURST = 2'd3
   } stop_fault_e;

   typedef struct packed {
      logic rd;
      logic wr;
      logic stop;
   } cmd_t;

   // Beats for a burst select code, clamped at the largest supported length.
   function automatic int burst_beats(input int sel, input int max_log2);
      int ex;
      ex = sel + 1;
      if (ex > max_log2) ex = max_log2;
      return 1 << ex;
   endfunction

endpackage

// File: rtl/rbs_cmd_decode.sv
module rbs_cmd_decode
   import rbs_pkg::*;
(
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output cmd_t cmd
);

   logic sel;

   always_comb begin
      sel      = !cs_n && ras_n;
      cmd.rd   = sel && !cas_n &&  we_n;
      cmd.wr   = sel && !cas_n && !we_n;
      cmd.stop = sel &&  cas_n && !we_n;
   end

endmodule

// File: rtl/rbs_wr_track.sv
module rbs_wr_track
   import rbs_pkg::*;
#(
   parameter int BL_SEL_W    = 2,
   parameter int BL_MAX_LOG2 = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_cmd,
   input  logic [BL_SEL_W-1:0] bl_sel,
   output logic                wr_busy
);

   localparam int BL_MAX = 1 << BL_MAX_LOG2;
   localparam int CNT_W  = BL_MAX_LOG2;

   logic [CNT_W-1:0] left_q;

   assign wr_busy = (left_q != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left_q <= '0;
      end else if (wr_cmd) begin
         left_q <= CNT_W'(burst_beats(int'(bl_sel), BL_MAX_LOG2) / 2);
      end else if (wr_busy) begin
         left_q <= left_q - CNT_W'(1);
      end
   end

   AST_WR_LEFT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      int'(left_q) <= BL_MAX / 2); // R7

   AST_WR_WINDOW_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_cmd && wr_busy) |=> left_q == $past(left_q) - CNT_W'(1)); // R7

endmodule

// File: rtl/rbs_rd_window.sv
module rbs_rd_window
   import rbs_pkg::*;
#(
   parameter int BL_SEL_W    = 2,
   parameter int BL_MAX_LOG2 = 3,
   parameter int CL_SEL_W    = 2,
   parameter int CLH_BASE    = 4,
   parameter int PRE_HALVES  = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rd_cmd,
   input  logic                wr_cmd,
   input  logic                stop_cmd,
   input  logic                auto_pre,
   input  logic [BL_SEL_W-1:0] bl_sel,
   input  logic [CL_SEL_W-1:0] cl_sel,
   output logic [1:0]          dq_vld,
   output logic [1:0]          dqs_en,
   output logic                rd_live,
   output logic                rd_ap
);

   localparam int BL_MAX   = 1 << BL_MAX_LOG2;
   localparam int CLH_MAX  = CLH_BASE + (1 << CL_SEL_W) - 1;
   localparam int SLOT_MAX = CLH_MAX + BL_MAX;
   localparam int SLOT_W   = $clog2(2 * SLOT_MAX + 4);
   localparam int PER_MAX  = SLOT_MAX / 2 + 1;

   typedef logic [SLOT_W-1:0] slot_t;

   slot_t per_q, clh_q, end_q;
   logic  run_q, ap_q;
   slot_t per_inc, stop_lim, per_nx, clh_nx, end_nx, beats_in;
   logic  run_nx, ap_nx;
   logic [1:0] vld_d, en_d;

   always_comb begin
      per_inc  = (per_q >= slot_t'(PER_MAX)) ? per_q : per_q + slot_t'(1);
      rd_live  = run_q && ((per_inc << 1) < end_q);
      stop_lim = (per_inc << 1) + clh_q;
      beats_in = slot_t'(burst_beats(int'(bl_sel), BL_MAX_LOG2));

      run_nx = run_q;
      per_nx = per_inc;
      clh_nx = clh_q;
      end_nx = end_q;
      ap_nx  = ap_q;

      if (wr_cmd) begin
         run_nx = 1'b0;
      end else if (rd_cmd) begin
         run_nx = 1'b1;
         per_nx = '0;
         clh_nx = slot_t'(CLH_BASE) + slot_t'(cl_sel);
         end_nx = clh_nx + beats_in;
         ap_nx  = auto_pre;
      end else begin
         if (!rd_live) run_nx = 1'b0;
         if (stop_cmd && rd_live && !ap_q && (stop_lim < end_q))
            end_nx = stop_lim;
      end
   end

   assign rd_ap = ap_q;

   for (genvar h = 0; h < 2; h++) begin : g_half
      slot_t slot_h;
      assign slot_h   = (per_nx << 1) + slot_t'(h);
      assign vld_d[h] = run_nx && (slot_h >= clh_nx) && (slot_h < end_nx);
      assign en_d[h]  = run_nx && ((slot_h + slot_t'(PRE_HALVES)) >= clh_nx)
                        && (slot_h < end_nx);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         per_q  <= '0;
         clh_q  <= slot_t'(CLH_BASE);
         end_q  <= '0;
         ap_q   <= 1'b0;
         dq_vld <= '0;
         dqs_en <= '0;
      end else begin
         run_q  <= run_nx;
         per_q  <= per_nx;
         clh_q  <= clh_nx;
         end_q  <= end_nx;
         ap_q   <= ap_nx;
         dq_vld <= vld_d;
         dqs_en <= en_d;
      end
   end

   AST_VLD_INSIDE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_vld & ~dqs_en) == 2'b00); // R4

   AST_WRITE_CLOSES_READ: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cmd |=> (dq_vld == 2'b00 && dqs_en == 2'b00)); // R10

   AST_STOP_NEVER_EXTENDS: assert property (@(posedge clk) disable iff (!rst_n)
      stop_cmd |=> end_q <= $past(end_q)); // R5

   AST_AP_READ_KEEPS_END: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_cmd && ap_q) |=> end_q == $past(end_q)); // R8

endmodule

// File: rtl/rd_burst_stop_seq.sv
module rd_burst_stop_seq
   import rbs_pkg::*;
#(
   parameter int BL_SEL_W    = 2,
   parameter int BL_MAX_LOG2 = 3,
   parameter int CL_SEL_W    = 2,
   parameter int CLH_BASE    = 4,
   parameter int PRE_HALVES  = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cs_n,
   input  logic                ras_n,
   input  logic                cas_n,
   input  logic                we_n,
   input  logic                auto_pre,
   input  logic [BL_SEL_W-1:0] bl_sel,
   input  logic [CL_SEL_W-1:0] cl_sel,
   output logic [1:0]          dq_valid,
   output logic [1:0]          dqs_oe,
   output logic [1:0]          stop_fault
);

   if (BL_MAX_LOG2 < 1 || BL_MAX_LOG2 > 4) begin : g_bad_bl
      $error("BL_MAX_LOG2 must lie in 1..4");
   end
   if (CLH_BASE < 2) begin : g_bad_cl
      $error("CLH_BASE must be at least 2 half cycles");
   end
   if (PRE_HALVES < 1 || PRE_HALVES > CLH_BASE) begin : g_bad_pre
      $error("PRE_HALVES must lie in 1..CLH_BASE");
   end

   cmd_t        cmd;
   logic        wr_busy, rd_live, rd_ap;
   stop_fault_e fault_q;

   rbs_cmd_decode u_dec (
      .cs_n  (cs_n),
      .ras_n (ras_n),
      .cas_n (cas_n),
      .we_n  (we_n),
      .cmd   (cmd)
   );

   rbs_wr_track #(
      .BL_SEL_W    (BL_SEL_W),
      .BL_MAX_LOG2 (BL_MAX_LOG2)
   ) u_wr (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_cmd  (cmd.wr),
      .bl_sel  (bl_sel),
      .wr_busy (wr_busy)
   );

   rbs_rd_window #(
      .BL_SEL_W    (BL_SEL_W),
      .BL_MAX_LOG2 (BL_MAX_LOG2),
      .CL_SEL_W    (CL_SEL_W),
      .CLH_BASE    (CLH_BASE),
      .PRE_HALVES  (PRE_HALVES)
   ) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_cmd   (cmd.rd),
      .wr_cmd   (cmd.wr),
      .stop_cmd (cmd.stop),
      .auto_pre (auto_pre),
      .bl_sel   (bl_sel),
      .cl_sel   (cl_sel),
      .dq_vld   (dq_valid),
      .dqs_en   (dqs_oe),
      .rd_live  (rd_live),
      .rd_ap    (rd_ap)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fault_q <= FLT_NONE;
      end else if (cmd.stop) begin
         if (rd_live)      fault_q <= rd_ap ? FLT_AP_READ : FLT_NONE;
         else if (wr_busy) fault_q <= FLT_IN_WRITE;
         else              fault_q <= FLT_NO_BURST;
      end else begin
         fault_q <= FLT_NONE;
      end
   end

   assign stop_fault = fault_q;

   AST_FAULT_NEEDS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_q != FLT_NONE) |-> $past(cmd.stop)); // R9

   AST_LEGAL_STOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.stop && rd_live && !rd_ap) |=> fault_q == FLT_NONE); // R6

   AST_WRITE_STOP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.stop && !rd_live && wr_busy) |=> fault_q == FLT_IN_WRITE); // R7

endmodule

// File: tb/tb_rd_burst_stop_seq.sv
`timescale 1ns/1ps
module tb_rd_burst_stop_seq;

   localparam int K_NOP   = 0;
   localparam int K_READ  = 1;
   localparam int K_WRITE = 2;
   localparam int K_STOP  = 3;
   localparam int K_DESEL = 4;
   localparam int K_ACT   = 5;
   localparam int K_REF   = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic auto_pre = 1'b0;
   logic [1:0] bl_sel = 2'd0, cl_sel = 2'd0;
   logic [1:0] dq_valid, dqs_oe, stop_fault;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;
   int e = 0;

   bit m_rd_on = 0, m_ap = 0, m_wr_on = 0;
   int m_t0 = 0, m_clh = 4, m_end = 0, m_wt0 = 0, m_wbl = 0;
   int exp_err = 0;

   rd_burst_stop_seq dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_n       (cs_n),
      .ras_n      (ras_n),
      .cas_n      (cas_n),
      .we_n       (we_n),
      .auto_pre   (auto_pre),
      .bl_sel     (bl_sel),
      .cl_sel     (cl_sel),
      .dq_valid   (dq_valid),
      .dqs_oe     (dqs_oe),
      .stop_fault (stop_fault)
   );

   initial forever #2.5 clk = ~clk;

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   function automatic int beats_of(input int sel);
      return (sel == 0) ? 2 : (sel == 1) ? 4 : 8;
   endfunction

   function automatic logic [3:0] pins_of(input int k);
      case (k)
         K_READ:  return 4'b0101;
         K_WRITE: return 4'b0100;
         K_STOP:  return 4'b0110;
         K_DESEL: return 4'b1110;
         K_ACT:   return 4'b0011;
         K_REF:   return 4'b0001;
         default: return 4'b0111;
      endcase
   endfunction

   function automatic logic [1:0] exp_win(input bit strobe);
      logic [1:0] r;
      r = 2'b00;
      if (m_rd_on) begin
         for (int h = 0; h < 2; h++) begin
            int slot;
            slot = 2 * (e - m_t0) + h;
            if (slot < m_end && slot >= (strobe ? m_clh - 1 : m_clh)) r[h] = 1'b1;
         end
      end
      return r;
   endfunction

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s at edge %0d: actual %0d expected %0d", tag, what, e, act, exp);
      end
   endtask

   task automatic model_edge(input int k, input int bl, input int cl, input bit ap);
      exp_err = 0;
      if (k == K_STOP) begin
         int s;
         s = e - m_t0;
         if (m_rd_on && 2 * s < m_end) begin
            if (m_ap) exp_err = 2;
            else if (2 * s + m_clh < m_end) m_end = 2 * s + m_clh;
         end else if (m_wr_on && (e - m_wt0) >= 1 && (e - m_wt0) <= m_wbl / 2) begin
            exp_err = 1;
         end else begin
            exp_err = 3;
         end
      end else if (k == K_READ) begin
         m_rd_on = 1; m_t0 = e; m_clh = 4 + cl; m_end = m_clh + beats_of(bl); m_ap = ap;
      end else if (k == K_WRITE) begin
         m_rd_on = 0; m_wr_on = 1; m_wt0 = e; m_wbl = beats_of(bl);
      end
   endtask

   task automatic step(input int k, input int bl, input int cl, input bit ap, input string tag);
      string etag;
      {cs_n, ras_n, cas_n, we_n} = pins_of(k);
      bl_sel = 2'(bl); cl_sel = 2'(cl); auto_pre = ap;
      @(posedge clk);
      e++;
      model_edge(k, bl, cl, ap);
      @(negedge clk);
      chk(tag, "dq_valid", int'(dq_valid), int'(exp_win(1'b0)));
      chk({"R4 ", tag}, "dqs_oe", int'(dqs_oe), int'(exp_win(1'b1)));
      case (exp_err)
         1: etag = "R7";
         2: etag = "R8";
         3: etag = "R9";
         default: etag = tag;
      endcase
      chk(etag, "stop_fault", int'(stop_fault), exp_err);
   endtask

   task automatic nops(input int n, input string tag);
      for (int i = 0; i < n; i++) step(K_NOP, 0, 0, 1'b0, tag);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R11", "dq_valid", int'(dq_valid), 0);
      chk("R11", "dqs_oe", int'(dqs_oe), 0);
      chk("R11", "stop_fault", int'(stop_fault), 0);
      rst_n = 1'b1;

      // R2 R3: plain reads, CL2 and CL3.5
      step(K_READ, 1, 0, 1'b0, "R2"); nops(6, "R2");
      step(K_READ, 2, 3, 1'b0, "R2"); nops(10, "R2");
      // R3: every burst length code
      for (int b = 0; b < 4; b++) begin
         step(K_READ, b, 1, 1'b0, "R3"); nops(9, "R3");
      end
      // R5: legal stops shortening the burst
      step(K_READ, 2, 1, 1'b0, "R5"); step(K_STOP, 0, 0, 1'b0, "R5"); nops(8, "R5");
      step(K_READ, 2, 0, 1'b0, "R5"); step(K_STOP, 0, 0, 1'b0, "R5"); nops(8, "R5");
      step(K_READ, 2, 3, 1'b0, "R5"); nops(2, "R5"); step(K_STOP, 0, 0, 1'b0, "R5"); nops(8, "R5");
      step(K_READ, 1, 2, 1'b0, "R5"); step(K_STOP, 0, 0, 1'b0, "R5"); nops(6, "R5");
      // R6: stops too late to remove a beat
      step(K_READ, 0, 0, 1'b0, "R6"); step(K_STOP, 0, 0, 1'b0, "R6"); nops(5, "R6");
      step(K_READ, 1, 0, 1'b0, "R6"); nops(1, "R6"); step(K_STOP, 0, 0, 1'b0, "R6"); nops(5, "R6");
      // R8: stop in read with auto-precharge
      step(K_READ, 2, 0, 1'b1, "R8"); nops(1, "R8"); step(K_STOP, 0, 0, 1'b0, "R8"); nops(8, "R8");
      // R7 R9: stops inside and just after a write window
      step(K_WRITE, 2, 0, 1'b0, "R7"); step(K_STOP, 0, 0, 1'b0, "R7"); nops(2, "R7");
      step(K_STOP, 0, 0, 1'b0, "R7"); step(K_STOP, 0, 0, 1'b0, "R9"); nops(2, "R9");
      // R9: idle stop and stop after a finished read
      step(K_STOP, 0, 0, 1'b0, "R9");
      step(K_READ, 0, 0, 1'b0, "R9"); nops(4, "R9"); step(K_STOP, 0, 0, 1'b0, "R9"); nops(2, "R9");
      // R1: deselected stop pattern and other commands ignored
      step(K_READ, 2, 0, 1'b0, "R1"); step(K_DESEL, 0, 0, 1'b0, "R1");
      step(K_ACT, 0, 0, 1'b0, "R1"); step(K_REF, 0, 0, 1'b0, "R1");
      step(K_DESEL, 0, 0, 1'b0, "R1"); nops(6, "R1");
      // R10: write aborts read, read restarts read
      step(K_READ, 2, 0, 1'b0, "R10"); nops(2, "R10"); step(K_WRITE, 0, 0, 1'b0, "R10"); nops(5, "R10");
      step(K_READ, 2, 0, 1'b0, "R10"); nops(1, "R10"); step(K_READ, 1, 1, 1'b0, "R10"); nops(8, "R10");

      // constrained random mix
      for (int i = 0; i < 3000; i++) begin
         int r, k;
         r = int'($urandom_range(99));
         if (r < 40) k = K_NOP;
         else if (r < 55) k = K_READ;
         else if (r < 75) k = K_STOP;
         else if (r < 83) k = K_WRITE;
         else if (r < 90) k = K_ACT;
         else k = K_DESEL;
         step(k, int'($urandom_range(3)), int'($urandom_range(3)),
              ($urandom_range(3) == 0), "R2");
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule